// File: doc/BRIEF.md
# Register-Mapped Serial Transfer Channel

This block is one channel of a memory-mapped serial master. Software programs it through a small 32-bit register window: a control/status word picks which of three attached peripherals is selected and how fast the serial clock runs, a data word holds the immediate payload, and a transfer word launches a 1-, 2- or 4-byte exchange in either direction. The channel then shifts the bits out on a four-wire synchronous link, most significant bit first, and gathers the reply bits from the peripheral.

Software starts an exchange by writing the transfer word with its start flag set, then polls that same flag until it reads back as zero. Payloads are kept left-justified in the data word, so a single-byte exchange always uses the top byte. The peripheral selects follow the control/status field directly, which lets software hold one peripheral selected across several exchanges.

Top module: `ser_xfer_chan`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, all three select outputs are high and the serial clock is low.
- R2: Control/status (offset 0x00) bits [9:7] drive the selects directly, select output i being the inverse of bit 7+i; bits [6:4] hold the rate code; both read back at those positions and other bits read zero. Writing zero to bits [9:7] raises every select.
- R3: A write to the transfer word (offset 0x0C) with bit 0 set, bit 1 clear and a legal length starts an exchange; bit 0 then reads 1 for exactly 2 x bit-count x 2^rate system clocks and returns to 0 by itself.
- R4: Transfer bits [5:4] hold the length as bytes minus one: 0 gives 8 bits, 1 gives 16, 3 gives 32. Code 2 is illegal and finishes at once with no serial clock edge.
- R5: Transfer bits [3:2] equal to 1 select a write; any other value selects a read. A write sends the data word (offset 0x10) from bit 31 downward, so a peripheral receives the top byte-count bytes in order.
- R6: The serial clock idles low, the data output changes only while the serial clock is low (on its falling edge or at a start), and the input is sampled on each rising edge.
- R7: A write leaves the data word unchanged; a read clears it at start and places the received bits left-justified, leaving unreceived low bits zero.
- R8: While an exchange is running, writes to the control/status, data and transfer words have no effect.
- R9: Setting transfer bit 1 (memory-transfer mode, not present here) together with bit 0 completes at once: bit 0 reads 0 on the next cycle and no serial clock edge occurs.
- R10: The memory address and length words (offsets 0x04 and 0x08) ignore writes and read zero.
- R11: Each half period of the serial clock lasts 2^rate system clocks for rate codes 0 to 6; code 7 behaves as code 6. The divider restarts at every start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write access, 0 = read access |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr while reg_en is high |
| ser_clk | output | 1 | Serial clock, idles low |
| ser_mosi | output | 1 | Serial data towards the peripheral |
| ser_miso | input | 1 | Serial data from the peripheral |
| ser_sel_n | output | 3 | Active-low peripheral selects |

## Verification
The bound checker watches, on every cycle, that the serial clock rests low outside an exchange and only toggles during one, that the data output holds steady while the clock is high, that the selects cannot move during an exchange, that the busy flag only rises after a start write, and that a memory-mode start never leaves the channel busy. The exact busy duration for each rate and length, the bit order seen by a peripheral, the left-justified read with zero fill, the alias of rate code 7 and the effect-free writes during an exchange are only shown by the bench's scenarios, which drive a peripheral model and compare against values computed from the requirements.

// File: rtl/ser_chan_pkg.sv
// Shared constants and helpers for the serial transfer channel.
// Assumes a 32-bit register word and byte offsets on a 5-bit address.
package ser_chan_pkg;

    localparam int          WORD_W     = 32;
    localparam logic [4:0]  OFS_CSR    = 5'h00;
    localparam logic [4:0]  OFS_MADDR  = 5'h04;
    localparam logic [4:0]  OFS_MLEN   = 5'h08;
    localparam logic [4:0]  OFS_XFER   = 5'h0C;
    localparam logic [4:0]  OFS_DATA   = 5'h10;

    localparam logic [1:0]  DIR_WRITE  = 2'd1;
    localparam logic [1:0]  LEN_BAD    = 2'd2;

    // Transfer-word fields that stay latched between exchanges.
    typedef struct packed {
        logic [1:0] len;
        logic [1:0] dir;
        logic       mem;
    } xfer_cfg_t;

    // Bit count of an immediate exchange from its length code.
    function automatic logic [5:0] len_to_bits(input logic [1:0] code);
        case (code)
            2'd0:    len_to_bits = 6'd8;
            2'd1:    len_to_bits = 6'd16;
            default: len_to_bits = 6'd32;
        endcase
    endfunction

endpackage

// File: rtl/ser_rate_div.sv
// Half-period tick generator for the serial clock.
// Produces one tick every 2^eff system clocks while run is high, with
// eff = min(code, MAX_CODE). Assumes restart is pulsed when an exchange starts.
module ser_rate_div #(
    parameter int CODE_W   = 3,
    parameter int MAX_CODE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    int               eff;

    // Terminal count: eff low bits set, rate codes above MAX_CODE clamped.
    always_comb begin
        eff = (int'(code) > MAX_CODE) ? MAX_CODE : int'(code);
        for (int i = 0; i < CNT_W; i++) begin
            lim[i] = (i < eff);
        end
    end

    assign tick = run && (cnt_q == lim);

    // Count system clocks within a half period; clear on start or tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ser_shift_eng.sv
// Mode-0 shift engine: clock idles low, output changes on the falling edge,
// input is sampled on the rising edge, MSB first.
// Assumes start only arrives while busy is low and nbits is 1..DW.
module ser_shift_eng #(
    parameter int DW    = 32,
    parameter int IDX_W = $clog2(DW),
    parameter int NB_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    tx_word,
    input  logic [NB_W-1:0]  nbits,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sclk,
    output logic             mosi,
    output logic             smp_en,
    output logic [IDX_W-1:0] smp_idx,
    output logic             smp_bit
);
    logic             busy_q;
    logic             sclk_q;
    logic [DW-1:0]    sh_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] last_q;

    // Sequence the serial clock phases and the outgoing shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            sh_q   <= '0;
            idx_q  <= '0;
            last_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
            sh_q   <= tx_word;
            idx_q  <= '0;
            last_q <= IDX_W'(nbits - 1'b1);
        end else if (busy_q && tick) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
            end else begin
                sclk_q <= 1'b0;
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    sh_q  <= {sh_q[DW-2:0], 1'b0};
                end
            end
        end
    end

    assign busy    = busy_q;
    assign sclk    = sclk_q;
    assign mosi    = sh_q[DW-1];
    assign smp_en  = busy_q && tick && !sclk_q;
    assign smp_idx = idx_q;
    assign smp_bit = miso;

endmodule

// File: rtl/ser_xfer_chan.sv
// One register-mapped serial transfer channel.
// Holds the control/status, transfer and data words, decodes accesses and
// runs immediate exchanges of 1, 2 or 4 bytes through the shift engine.
// Assumes single-cycle register accesses; reads are combinational.
module ser_xfer_chan
    import ser_chan_pkg::*;
#(
    parameter int N_DEV    = 3,
    parameter int RATE_W   = 3,
    parameter int MAX_RATE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_en,
    input  logic             reg_we,
    input  logic [4:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             ser_clk,
    output logic             ser_mosi,
    input  logic             ser_miso,
    output logic [N_DEV-1:0] ser_sel_n
);
    localparam int DW       = WORD_W;
    localparam int IDX_W    = $clog2(DW);
    localparam int NB_W     = IDX_W + 1;
    localparam int SEL_LSB  = 7;
    localparam int RATE_LSB = 4;

    logic [N_DEV-1:0]  csr_sel;
    logic [RATE_W-1:0] csr_rate;
    xfer_cfg_t         cfg_q;
    logic [DW-1:0]     data_q;

    logic             xfer_busy;
    logic             tick;
    logic             smp_en;
    logic [IDX_W-1:0] smp_idx;
    logic             smp_bit;
    logic [DW-1:0]    smp_mask;

    logic          wr_csr, wr_xfer, wr_data;
    logic          start;
    logic          start_wr;
    logic [DW-1:0] tx_word;

    // Decode writes; all are blocked while an exchange runs.
    always_comb begin
        wr_csr   = reg_en && reg_we && !xfer_busy && (reg_addr == OFS_CSR);
        wr_xfer  = reg_en && reg_we && !xfer_busy && (reg_addr == OFS_XFER);
        wr_data  = reg_en && reg_we && !xfer_busy && (reg_addr == OFS_DATA);
        start    = wr_xfer && reg_wdata[0] && !reg_wdata[1]
                   && (reg_wdata[5:4] != LEN_BAD);
        start_wr = (reg_wdata[3:2] == DIR_WRITE);
        tx_word  = start_wr ? data_q : '0;
        smp_mask = {1'b1, {(DW-1){1'b0}}} >> smp_idx;
    end

    // Control/status word: peripheral select and rate code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_sel  <= '0;
            csr_rate <= '0;
        end else if (wr_csr) begin
            csr_sel  <= reg_wdata[SEL_LSB +: N_DEV];
            csr_rate <= reg_wdata[RATE_LSB +: RATE_W];
        end
    end

    // Transfer word fields kept for read-back and direction during a run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_xfer) begin
            cfg_q.len <= reg_wdata[5:4];
            cfg_q.dir <= reg_wdata[3:2];
            cfg_q.mem <= reg_wdata[1];
        end
    end

    // Data word: software writes, cleared at a read start, filled per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (wr_data) begin
            data_q <= reg_wdata;
        end else if (start && !start_wr) begin
            data_q <= '0;
        end else if (smp_en && (cfg_q.dir != DIR_WRITE)) begin
            data_q <= smp_bit ? (data_q | smp_mask) : (data_q & ~smp_mask);
        end
    end

    // Register read multiplexer; memory-transfer words read as zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_en) begin
            case (reg_addr)
                OFS_CSR: begin
                    reg_rdata[SEL_LSB +: N_DEV]   = csr_sel;
                    reg_rdata[RATE_LSB +: RATE_W] = csr_rate;
                end
                OFS_XFER: reg_rdata[5:0] = {cfg_q.len, cfg_q.dir, cfg_q.mem, xfer_busy};
                OFS_DATA: reg_rdata      = data_q;
                default:  reg_rdata      = '0;
            endcase
        end
    end

    assign ser_sel_n = ~csr_sel;

    ser_rate_div #(
        .CODE_W   (RATE_W),
        .MAX_CODE (MAX_RATE)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (xfer_busy),
        .restart (start),
        .code    (csr_rate),
        .tick    (tick)
    );

    ser_shift_eng #(
        .DW (DW)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tx_word (tx_word),
        .nbits   (NB_W'(len_to_bits(reg_wdata[5:4]))),
        .tick    (tick),
        .miso    (ser_miso),
        .busy    (xfer_busy),
        .sclk    (ser_clk),
        .mosi    (ser_mosi),
        .smp_en  (smp_en),
        .smp_idx (smp_idx),
        .smp_bit (smp_bit)
    );

endmodule

// File: rtl/ser_xfer_chan_chk.sv
// Cycle-level properties of the serial transfer channel, bound to its top.
// Assumes the internal busy flag is reachable as xfer_busy.
module ser_xfer_chan_chk
    import ser_chan_pkg::*;
#(
    parameter int N_DEV = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_en,
    input logic             reg_we,
    input logic [4:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic             ser_clk,
    input logic             ser_mosi,
    input logic [N_DEV-1:0] ser_sel_n,
    input logic             busy
);
    logic xfer_wr;
    assign xfer_wr = reg_en && reg_we && (reg_addr == OFS_XFER);

    AST_IDLE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ser_clk); // R6

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> $stable(ser_mosi)); // R6

    AST_CLK_MOVES_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk != $past(ser_clk)) |-> (busy || $past(busy))); // R6

    AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ser_sel_n)); // R8

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(xfer_wr && reg_wdata[0] && !reg_wdata[1])); // R3

    AST_MEM_MODE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_wr && reg_wdata[1] && !busy) |=> !busy); // R9

endmodule

bind ser_xfer_chan ser_xfer_chan_chk #(.N_DEV(N_DEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ser_clk   (ser_clk),
    .ser_mosi  (ser_mosi),
    .ser_sel_n (ser_sel_n),
    .busy      (xfer_busy)
);

// File: tb/test_ser_xfer_chan.sv
module test_ser_xfer_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ser_clk;
    logic        ser_mosi;
    logic        ser_miso = 1'b0;
    logic [2:0]  ser_sel_n;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ser_xfer_chan i_ser_xfer_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_en    (reg_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ser_clk   (ser_clk),
        .ser_mosi  (ser_mosi),
        .ser_miso  (ser_miso),
        .ser_sel_n (ser_sel_n)
    );

    // Peripheral model: mode 0, captures on rise, presents next bit after fall.
    logic [31:0] slv_rx = '0;
    logic [31:0] slv_pat = '0;
    int          slv_edges = 0;

    always @(posedge ser_clk) begin
        slv_rx    = {slv_rx[30:0], ser_mosi};
        slv_edges = slv_edges + 1;
    end

    always @(negedge ser_clk) begin
        slv_pat  = slv_pat << 1;
        ser_miso = slv_pat[31];
    end

    task automatic slave_arm(input logic [31:0] pat);
        slv_pat   = pat;
        ser_miso  = pat[31];
        slv_rx    = '0;
        slv_edges = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling clock edge; the write lands at the next rising edge.
    task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
        reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
        reg_en = 1'b0;
    endtask

    // Count cycles with the start bit still reading 1.
    task automatic wait_done(output int cyc);
        logic [31:0] v;
        cyc = 0;
        forever begin
            bus_rd(5'h0C, v);
            if (!v[0] || cyc > 20000) break;
            cyc++;
            @(negedge clk);
        end
    endtask

    // Vector: {rate[3], len[2], dir[2], wdata[32], peripheral pattern[32]}
    localparam int NV = 8;
    localparam logic [70:0] VEC [NV] = '{
        {3'd0, 2'd0, 2'd1, 32'hA5000000, 32'h00000000},
        {3'd1, 2'd1, 2'd1, 32'h1234FFFF, 32'h00000000},
        {3'd0, 2'd3, 2'd1, 32'hDEADBEEF, 32'h00000000},
        {3'd2, 2'd0, 2'd0, 32'h00000000, 32'hC3FFFFFF},
        {3'd0, 2'd1, 2'd0, 32'h00000000, 32'h80017777},
        {3'd1, 2'd3, 2'd0, 32'h00000000, 32'h0F1E2D3C},
        {3'd7, 2'd0, 2'd0, 32'h00000000, 32'h5A5A5A5A},
        {3'd3, 2'd3, 2'd2, 32'h00000000, 32'h96969696}
    };

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int          cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        bus_rd(5'h00, v); chk("R1 csr", v, 32'h0);
        bus_rd(5'h0C, v); chk("R1 xfer", v, 32'h0);
        bus_rd(5'h10, v); chk("R1 data", v, 32'h0);
        chk("R1 sel_n", {29'd0, ser_sel_n}, 32'h7);
        chk("R1 sclk", {31'd0, ser_clk}, 32'h0);

        // R10: memory-transfer words read zero and ignore writes
        bus_wr(5'h04, 32'h12345678);
        bus_wr(5'h08, 32'h00000100);
        bus_rd(5'h04, v); chk("R10 addr word", v, 32'h0);
        bus_rd(5'h08, v); chk("R10 len word", v, 32'h0);

        // Table walk: R2 R3 R4 R5 R6 R7 R11
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  rate  = VEC[i][70:68];
            logic [1:0]  len   = VEC[i][67:66];
            logic [1:0]  dir   = VEC[i][65:64];
            logic [31:0] wd    = VEC[i][63:32];
            logic [31:0] pat   = VEC[i][31:0];
            int          nb    = (len == 2'd3) ? 32 : (int'(len) + 1) * 8;
            int          eff   = (rate > 3'd6) ? 6 : int'(rate);
            logic [2:0]  sel   = 3'b001 << (i % 3);
            logic [31:0] csr   = {22'd0, sel, rate, 4'd0};
            bus_wr(5'h00, csr);
            bus_rd(5'h00, v); chk("R2 csr readback", v, csr);
            chk("R2 sel_n", {29'd0, ser_sel_n}, {29'd0, ~sel});
            bus_wr(5'h10, (dir == 2'd1) ? wd : 32'hFFFFFFFF);
            slave_arm(pat);
            bus_wr(5'h0C, {26'd0, len, dir, 2'b01});
            wait_done(cyc);
            chk("R3 R11 busy cycles", cyc, 2 * nb * (1 << eff));
            chk("R4 clock edges", slv_edges, nb);
            chk("R6 sclk idle", {31'd0, ser_clk}, 32'h0);
            bus_rd(5'h10, v);
            if (dir == 2'd1) begin
                chk("R5 peripheral received", slv_rx, wd >> (32 - nb));
                chk("R7 data kept on write", v, wd);
            end else begin
                chk("R7 R6 read left-justified", v, (pat >> (32 - nb)) << (32 - nb));
            end
        end

        // R8: writes during a run have no effect
        bus_wr(5'h00, {22'd0, 3'b010, 3'd3, 4'd0});
        bus_wr(5'h10, 32'hC0FFEE11);
        slave_arm(32'h0);
        bus_wr(5'h0C, 32'h35);
        bus_wr(5'h10, 32'h11111111);
        bus_wr(5'h00, 32'h380);
        bus_wr(5'h0C, 32'h05);
        bus_rd(5'h10, v); chk("R8 data unchanged", v, 32'hC0FFEE11);
        bus_rd(5'h00, v); chk("R8 csr unchanged", v, {22'd0, 3'b010, 3'd3, 4'd0});
        chk("R8 sel_n unchanged", {29'd0, ser_sel_n}, 32'h5);
        wait_done(cyc);
        chk("R8 no restart edges", slv_edges, 32);
        chk("R8 R5 word sent", slv_rx, 32'hC0FFEE11);
        bus_rd(5'h0C, v); chk("R8 xfer fields kept", v, 32'h34);

        // R9: memory mode completes at once, no clock
        slave_arm(32'h0);
        bus_wr(5'h0C, 32'h07);
        bus_rd(5'h0C, v); chk("R9 start cleared", {31'd0, v[0]}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R9 no edges", slv_edges, 0);

        // R4: illegal length code 2
        bus_wr(5'h0C, 32'h25);
        bus_rd(5'h0C, v); chk("R4 bad length cleared", {31'd0, v[0]}, 32'h0);
        repeat (20) @(negedge clk);
        chk("R4 bad length no edges", slv_edges, 0);

        // R2: deselect all
        bus_wr(5'h00, 32'h0);
        chk("R2 deselect", {29'd0, ser_sel_n}, 32'h7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule